// File: doc/BRIEF.md
# Fixed-Sequence VOQ Switch Stage

This block is the buffering core of a two-stage load-balanced packet switch with `NPORT` ports. Fixed-size packets arrive on the input ports. Each packet carries the index of the output it must finally leave on. A spreading crossbar moves every arriving packet, in the same cycle it arrives, to one intermediate input. That intermediate input writes the packet into the virtual output queue (VOQ) kept for the packet's final output. A serving crossbar then connects each intermediate input to one output port and presents the head of the matching VOQ there.

Neither crossbar looks at queue occupancy. Both follow a fixed rotation that a shared modulo-`NPORT` slot counter drives, and both change setting on the same clock edge. Over any `NPORT` consecutive slots each input meets every intermediate input once, and each intermediate input meets every output once, so every VOQ is guaranteed one service slot in `NPORT`. No arbiter exists, and the input side never applies back-pressure. A packet whose target VOQ is full is discarded and counted against the input it came from.

The port numbering below is 0-based. In slot `t`, a port `i` on either crossbar faces port `(i + t) mod NPORT` on the far side.

Top module: `lbs_voq_stage`

## Requirements
- R1: After reset the slot index is 0, every VOQ is empty, every `out_valid` bit is low and every drop count is 0.
- R2: `cur_slot` advances by one on every clock edge out of reset, and wraps from `NPORT-1` to 0.
- R3: A valid packet on input `i` during slot `t` is written on the next edge into intermediate input `(i + t) mod NPORT`, in the VOQ whose index equals its `in_dest` field (bits `i*log2(NPORT)` upward). It appears unchanged on `out_data` of that output port.
- R4: Over any `NPORT` consecutive slots a given input lands on each intermediate input exactly once, whatever the traffic.
- R5: During slot `t`, output `p` presents the head of VOQ `p` held at intermediate input `(p - t) mod NPORT`. `out_valid[p]` is high exactly when that VOQ is non-empty.
- R6: When the connected VOQ is empty, the output port stays idle for that slot (`out_valid` low).
- R7: A VOQ head is removed only on an edge where `out_valid` and `out_ready` of its port are both high. Otherwise it stays, and each VOQ delivers its packets in arrival order.
- R8: When the target VOQ already holds `DEPTH` packets at the edge (measured before any removal in that cycle), the packet is discarded and the drop count of its input rises by one, saturating at its maximum. `in_ready` stays high at all times.
- R9: A write into and a removal from the same VOQ on one edge both take effect.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| in_valid | input | NPORT | Packet present on each input port |
| in_ready | output | NPORT | Always high; the stage never stalls an input |
| in_data | input | NPORT*DATA_W | Packet payload per input, port i in bits i*DATA_W upward |
| in_dest | input | NPORT*log2(NPORT) | Final output index per input |
| out_valid | output | NPORT | Packet present on each output port |
| out_ready | input | NPORT | Downstream accepts the packet on each output port |
| out_data | output | NPORT*DATA_W | Packet payload per output |
| drop_count | output | NPORT*DROP_W | Saturating count of discarded packets per input |
| cur_slot | output | log2(NPORT) | Current crossbar rotation index |

## Verification
Arrivals take one edge to reach a VOQ. The output side is combinational from VOQ state and the slot, so a packet written on edge k can appear on its output during the slot after edge k. A removal and a drop-count increment both land on the next edge. The bench drives inputs just after a falling edge and advances its behavioural queue model by one edge in the same step. At the next falling edge it compares the slot, every output and every drop count against that model. Each expected value is therefore due exactly one edge after the stimulus that caused it.

// File: rtl/lbs_pkg.sv
package lbs_pkg;

    // rotation arithmetic shared by both crossbars
    function automatic int rot_fwd(int a, int b, int n);
        return (a + b) % n;
    endfunction

    function automatic int rot_back(int a, int b, int n);
        return (a - b + n) % n;
    endfunction

endpackage

// File: rtl/lbs_slot_counter.sv
module lbs_slot_counter #(
    parameter int NPORT = 4,
    parameter int IDX_W = 2
) (
    input  logic             clk,
    input  logic             rst_n,
    output logic [IDX_W-1:0] slot
);

    logic [IDX_W-1:0] slot_q;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            slot_q <= '0;
        end else if (slot_q == IDX_W'(NPORT - 1)) begin
            slot_q <= '0;
        end else begin
            slot_q <= slot_q + 1'b1;
        end
    end

    assign slot = slot_q;

    AST_SLOT_WRAP: assert property (@(posedge clk) disable iff (!rst_n)
        (slot_q == IDX_W'(NPORT - 1)) |=> (slot_q == '0)); // R2

    AST_SLOT_STEP: assert property (@(posedge clk) disable iff (!rst_n)
        (slot_q != IDX_W'(NPORT - 1)) |=> (slot_q == IDX_W'($past(slot_q) + 1'b1))); // R2

endmodule

// File: rtl/lbs_voq_fifo.sv
module lbs_voq_fifo #(
    parameter int DATA_W = 8,
    parameter int DEPTH  = 4
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              push,
    input  logic [DATA_W-1:0] push_data,
    input  logic              pop,
    output logic [DATA_W-1:0] head,
    output logic              empty,
    output logic              full
);

    localparam int PTR_W = (DEPTH > 1) ? $clog2(DEPTH) : 1;
    localparam int CNT_W = $clog2(DEPTH + 1);

    logic [DATA_W-1:0] mem [DEPTH];
    logic [PTR_W-1:0]  wr_q, rd_q;
    logic [CNT_W-1:0]  cnt_q;

    always_ff @(posedge clk) begin
        if (push) begin
            mem[wr_q] <= push_data;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            wr_q  <= '0;
            rd_q  <= '0;
            cnt_q <= '0;
        end else begin
            if (push) begin
                wr_q <= (wr_q == PTR_W'(DEPTH - 1)) ? '0 : wr_q + 1'b1;
            end
            if (pop) begin
                rd_q <= (rd_q == PTR_W'(DEPTH - 1)) ? '0 : rd_q + 1'b1;
            end
            unique case ({push, pop})
                2'b10:   cnt_q <= cnt_q + 1'b1;
                2'b01:   cnt_q <= cnt_q - 1'b1;
                default: cnt_q <= cnt_q;
            endcase
        end
    end

    assign head  = mem[rd_q];
    assign empty = (cnt_q == '0);
    assign full  = (cnt_q == CNT_W'(DEPTH));

    AST_NO_OVERFLOW: assert property (@(posedge clk) disable iff (!rst_n)
        push |-> !full); // R8

    AST_NO_UNDERFLOW: assert property (@(posedge clk) disable iff (!rst_n)
        pop |-> !empty); // R7

endmodule

// File: rtl/lbs_spread_xbar.sv
module lbs_spread_xbar
    import lbs_pkg::*;
#(
    parameter int NPORT  = 4,
    parameter int DATA_W = 8,
    parameter int IDX_W  = 2
) (
    input  logic [IDX_W-1:0]        slot,
    input  logic [NPORT-1:0]        in_valid,
    input  logic [NPORT*DATA_W-1:0] in_data,
    input  logic [NPORT*IDX_W-1:0]  in_dest,
    output logic [NPORT-1:0]        mid_valid,
    output logic [NPORT*DATA_W-1:0] mid_data,
    output logic [NPORT*IDX_W-1:0]  mid_dest,
    output logic [NPORT*IDX_W-1:0]  land_idx
);

    for (genvar m = 0; m < NPORT; m++) begin : g_mid
        logic [IDX_W-1:0] src;
        assign src = IDX_W'(rot_back(m, int'(slot), NPORT));
        assign mid_valid[m]                   = in_valid[src];
        assign mid_data[m*DATA_W +: DATA_W]   = in_data[src*DATA_W +: DATA_W];
        assign mid_dest[m*IDX_W +: IDX_W]     = in_dest[src*IDX_W +: IDX_W];
    end

    for (genvar i = 0; i < NPORT; i++) begin : g_land
        assign land_idx[i*IDX_W +: IDX_W] = IDX_W'(rot_fwd(i, int'(slot), NPORT));
    end

endmodule

// File: rtl/lbs_serve_xbar.sv
module lbs_serve_xbar
    import lbs_pkg::*;
#(
    parameter int NPORT  = 4,
    parameter int DATA_W = 8,
    parameter int IDX_W  = 2
) (
    input  logic                          clk,
    input  logic                          rst_n,
    input  logic [IDX_W-1:0]              slot,
    input  logic [NPORT*NPORT-1:0]        voq_empty,
    input  logic [NPORT*NPORT*DATA_W-1:0] voq_head,
    input  logic [NPORT-1:0]              out_ready,
    output logic [NPORT-1:0]              out_valid,
    output logic [NPORT*DATA_W-1:0]       out_data,
    output logic [NPORT*NPORT-1:0]        voq_pop
);

    localparam int K_W = $clog2(NPORT * NPORT);

    for (genvar p = 0; p < NPORT; p++) begin : g_out
        logic [IDX_W-1:0] src;
        logic [K_W-1:0]   sel;
        logic [NPORT-1:0] col_pop;

        assign src = IDX_W'(rot_back(p, int'(slot), NPORT));
        assign sel = K_W'(int'(src) * NPORT + p);
        assign out_valid[p]                 = !voq_empty[sel];
        assign out_data[p*DATA_W +: DATA_W] = voq_head[sel*DATA_W +: DATA_W];

        for (genvar m = 0; m < NPORT; m++) begin : g_row
            assign voq_pop[m*NPORT + p] = out_ready[p] && !voq_empty[m*NPORT + p]
                                          && (src == IDX_W'(m));
            assign col_pop[m] = voq_pop[m*NPORT + p];
        end

        AST_ONE_POP_PER_OUTPUT: assert property (@(posedge clk) disable iff (!rst_n)
            $onehot0(col_pop)); // R5

        AST_POP_NEEDS_VALID: assert property (@(posedge clk) disable iff (!rst_n)
            (|col_pop) |-> (out_valid[p] && out_ready[p])); // R7
    end

endmodule

// File: rtl/lbs_voq_stage.sv
module lbs_voq_stage #(
    parameter int NPORT  = 4,
    parameter int DEPTH  = 4,
    parameter int DATA_W = 8,
    parameter int DROP_W = 16
) (
    input  logic                              clk,
    input  logic                              rst_n,
    input  logic [NPORT-1:0]                  in_valid,
    output logic [NPORT-1:0]                  in_ready,
    input  logic [NPORT*DATA_W-1:0]           in_data,
    input  logic [NPORT*$clog2(NPORT)-1:0]    in_dest,
    output logic [NPORT-1:0]                  out_valid,
    input  logic [NPORT-1:0]                  out_ready,
    output logic [NPORT*DATA_W-1:0]           out_data,
    output logic [NPORT*DROP_W-1:0]           drop_count,
    output logic [$clog2(NPORT)-1:0]          cur_slot
);

    localparam int IDX_W = $clog2(NPORT);
    localparam int NVOQ  = NPORT * NPORT;
    localparam int K_W   = $clog2(NVOQ);

    logic [IDX_W-1:0]         slot;
    logic [NPORT-1:0]         mid_valid;
    logic [NPORT*DATA_W-1:0]  mid_data;
    logic [NPORT*IDX_W-1:0]   mid_dest;
    logic [NPORT*IDX_W-1:0]   land_idx;
    logic [NVOQ-1:0]          voq_push, voq_pop, voq_empty, voq_full;
    logic [NVOQ*DATA_W-1:0]   voq_head;
    logic [NPORT-1:0]         drop_hit;
    logic [DROP_W-1:0]        drop_q [NPORT];

    lbs_slot_counter #(.NPORT(NPORT), .IDX_W(IDX_W)) u_slot (
        .clk   (clk),
        .rst_n (rst_n),
        .slot  (slot)
    );

    lbs_spread_xbar #(.NPORT(NPORT), .DATA_W(DATA_W), .IDX_W(IDX_W)) u_spread (
        .slot      (slot),
        .in_valid  (in_valid),
        .in_data   (in_data),
        .in_dest   (in_dest),
        .mid_valid (mid_valid),
        .mid_data  (mid_data),
        .mid_dest  (mid_dest),
        .land_idx  (land_idx)
    );

    // VOQ k = m*NPORT + q : intermediate input m, final output q
    for (genvar m = 0; m < NPORT; m++) begin : g_mid
        for (genvar q = 0; q < NPORT; q++) begin : g_voq
            localparam int K = m * NPORT + q;

            assign voq_push[K] = mid_valid[m]
                                 && (mid_dest[m*IDX_W +: IDX_W] == IDX_W'(q))
                                 && !voq_full[K];

            lbs_voq_fifo #(.DATA_W(DATA_W), .DEPTH(DEPTH)) u_fifo (
                .clk       (clk),
                .rst_n     (rst_n),
                .push      (voq_push[K]),
                .push_data (mid_data[m*DATA_W +: DATA_W]),
                .pop       (voq_pop[K]),
                .head      (voq_head[K*DATA_W +: DATA_W]),
                .empty     (voq_empty[K]),
                .full      (voq_full[K])
            );
        end

        AST_ONE_WRITE_PER_MID: assert property (@(posedge clk) disable iff (!rst_n)
            $onehot0(voq_push[m*NPORT +: NPORT])); // R3
    end

    lbs_serve_xbar #(.NPORT(NPORT), .DATA_W(DATA_W), .IDX_W(IDX_W)) u_serve (
        .clk       (clk),
        .rst_n     (rst_n),
        .slot      (slot),
        .voq_empty (voq_empty),
        .voq_head  (voq_head),
        .out_ready (out_ready),
        .out_valid (out_valid),
        .out_data  (out_data),
        .voq_pop   (voq_pop)
    );

    for (genvar i = 0; i < NPORT; i++) begin : g_drop
        logic [K_W-1:0] tgt;
        assign tgt = K_W'(int'(land_idx[i*IDX_W +: IDX_W]) * NPORT
                          + int'(in_dest[i*IDX_W +: IDX_W]));
        assign drop_hit[i] = in_valid[i] && voq_full[tgt];

        always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) begin
                drop_q[i] <= '0;
            end else if (drop_hit[i] && (drop_q[i] != '1)) begin
                drop_q[i] <= drop_q[i] + 1'b1;
            end
        end

        assign drop_count[i*DROP_W +: DROP_W] = drop_q[i];

        AST_DROP_MONOTONE: assert property (@(posedge clk) disable iff (!rst_n)
            !drop_hit[i] |=> (drop_q[i] == $past(drop_q[i]))); // R8
    end

    assign in_ready = '1;
    assign cur_slot = slot;

endmodule

// File: tb/test_lbs_voq_stage.sv
module test_lbs_voq_stage;

    localparam int N          = 4;
    localparam int DEPTH      = 4;
    localparam int DW         = 8;
    localparam int IW         = 2;
    localparam int CW         = 16;
    localparam int CLK_PERIOD = 10;

    logic              clk = 1'b0;
    logic              rst_n;
    logic [N-1:0]      in_valid, in_ready, out_valid, out_ready;
    logic [N*DW-1:0]   in_data, out_data;
    logic [N*IW-1:0]   in_dest;
    logic [N*CW-1:0]   drop_count;
    logic [IW-1:0]     cur_slot;

    always #(CLK_PERIOD/2) clk = ~clk;

    lbs_voq_stage #(.NPORT(N), .DEPTH(DEPTH), .DATA_W(DW), .DROP_W(CW)) i_lbs_voq_stage (
        .clk        (clk),
        .rst_n      (rst_n),
        .in_valid   (in_valid),
        .in_ready   (in_ready),
        .in_data    (in_data),
        .in_dest    (in_dest),
        .out_valid  (out_valid),
        .out_ready  (out_ready),
        .out_data   (out_data),
        .drop_count (drop_count),
        .cur_slot   (cur_slot)
    );

    int n_tests = 0;
    int n_fail  = 0;
    int ms      = 0;
    int seq     = 1;
    int out0_seen = 0;
    int mdrop [N];
    int mq [N][N][$];

    task automatic check_val(string tag, string what, int act, int exp);
        n_tests++;
        if (act != exp) begin
            n_fail++;
            $display("FAIL %s %s actual=%0d expected=%0d", tag, what, act, exp);
        end
    endtask

    task automatic compare(string tag);
        check_val({tag, " R2"}, "cur_slot", int'(cur_slot), ms);
        for (int p = 0; p < N; p++) begin
            int m;
            int ev;
            m  = (p - ms + N) % N;
            ev = (mq[m][p].size() > 0) ? 1 : 0;
            check_val({tag, " R5"}, $sformatf("out_valid[%0d]", p), int'(out_valid[p]), ev);
            if (ev == 1) begin
                check_val({tag, " R3"}, $sformatf("out_data[%0d]", p),
                          int'(out_data[p*DW +: DW]), mq[m][p][0]);
            end
        end
        for (int i = 0; i < N; i++) begin
            check_val({tag, " R8"}, $sformatf("drop_count[%0d]", i),
                      int'(drop_count[i*CW +: CW]), mdrop[i]);
        end
        check_val({tag, " R8"}, "in_ready", int'(in_ready), (1 << N) - 1);
    endtask

    task automatic drive_update(logic [N-1:0] v, logic [N*IW-1:0] dst, logic [N-1:0] rdy);
        int land [N];
        int dq   [N];
        int dv   [N];
        bit hit  [N];
        for (int i = 0; i < N; i++) begin
            logic [DW-1:0] d;
            d = DW'(seq);
            seq++;
            in_data[i*DW +: DW] = d;
            dv[i]   = int'(d);
            land[i] = (i + ms) % N;
            dq[i]   = int'(dst[i*IW +: IW]);
            hit[i]  = v[i] && (mq[land[i]][dq[i]].size() >= DEPTH);
        end
        in_valid  = v;
        in_dest   = dst;
        out_ready = rdy;
        for (int p = 0; p < N; p++) begin
            int m;
            m = (p - ms + N) % N;
            if (rdy[p] && mq[m][p].size() > 0) begin
                if (p == 0) out0_seen++;
                void'(mq[m][p].pop_front());
            end
        end
        for (int i = 0; i < N; i++) begin
            if (v[i]) begin
                if (hit[i]) mdrop[i]++;
                else mq[land[i]][dq[i]].push_back(dv[i]);
            end
        end
        ms = (ms + 1) % N;
    endtask

    task automatic run_cycle(string tag, logic [N-1:0] v, logic [N*IW-1:0] dst, logic [N-1:0] rdy);
        @(negedge clk);
        compare(tag);
        drive_update(v, dst, rdy);
    endtask

    function automatic logic [N*IW-1:0] all_dest(int d);
        logic [N*IW-1:0] r;
        for (int i = 0; i < N; i++) r[i*IW +: IW] = IW'(d);
        return r;
    endfunction

    task automatic finish_run();
        $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
        $finish;
    endtask

    initial begin
        #(CLK_PERIOD * 100000);
        n_fail++;
        $display("FAIL R1 watchdog actual=timeout expected=completion");
        finish_run();
    end

    initial begin
        int total;
        logic [N*IW-1:0] dst;
        for (int i = 0; i < N; i++) mdrop[i] = 0;
        rst_n     = 1'b0;
        in_valid  = '0;
        in_data   = '0;
        in_dest   = '0;
        out_ready = '0;
        repeat (3) @(posedge clk);
        @(negedge clk);
        rst_n = 1'b1;

        // R1: reset state
        check_val("R1", "out_valid", int'(out_valid), 0);
        check_val("R1", "cur_slot", int'(cur_slot), 0);
        compare("R1");
        drive_update('0, '0, '1);

        // R2: idle rotation with wrap
        for (int c = 0; c < 2 * N; c++) run_cycle("R2", '0, '0, '1);

        // R3: one packet per input, distinct destinations
        for (int i = 0; i < N; i++) begin
            dst = '0;
            dst[i*IW +: IW] = IW'((i + 1) % N);
            run_cycle("R3", N'(1 << i), dst, '1);
        end
        for (int c = 0; c < 2 * N; c++) run_cycle("R3", '0, '0, '1);

        // R4: input 0 over N slots, held back, then drained on output 0
        for (int c = 0; c < N; c++) run_cycle("R4", N'(1), all_dest(0), '0);
        out0_seen = 0;
        for (int c = 0; c < N; c++) run_cycle("R4", '0, '0, '1);
        check_val("R4", "packets seen on output 0 in N slots", out0_seen, N);

        // R6: empty stage stays idle
        for (int c = 0; c < N; c++) run_cycle("R6", '0, '0, '1);

        // R8: overload one output with no service
        for (int c = 0; c < 3 * N * DEPTH; c++) run_cycle("R8", '1, all_dest(2), '0);
        @(negedge clk);
        compare("R8");
        total = 0;
        for (int i = 0; i < N; i++) total += int'(drop_count[i*CW +: CW]);
        check_val("R8", "drops occurred", (total > 0) ? 1 : 0, 1);
        drive_update('0, '0, '1);

        // R7: drain in order, then random back-pressure
        for (int c = 0; c < N * DEPTH + N; c++) run_cycle("R7", '0, '0, '1);
        for (int c = 0; c < 1500; c++)
            run_cycle("R7", N'($urandom), (N*IW)'($urandom), N'($urandom));

        // R9: heavy traffic, always ready, simultaneous write and removal
        for (int c = 0; c < 1500; c++)
            run_cycle("R9", '1, (N*IW)'($urandom), '1);

        @(negedge clk);
        compare("R9");
        finish_run();
    end

endmodule